// File: doc/BRIEF.md
# BLAKE2b Quarter-Round Mixer

This unit performs the mixing function that BLAKE2b applies to one column or one diagonal of its sixteen-word working state. It accepts four 64-bit state words (a, b, c, d) and two 64-bit message words (x, y). It returns the four words after two half-steps. Each half-step adds, XORs and rotates in a fixed order. The first half-step folds in x with rotations of 32 and 24. The second folds in y with rotations of 16 and 63.

The unit is a pure datapath. Choosing the message words, sequencing the rounds and storing the state matrix are left to the surrounding logic. A qualifier travels alongside the data. The qualifier and the result leave after a fixed number of clock cycles, chosen at build time: zero, one or two. A new set of operands can be accepted on every cycle, whatever the latency.

Top module: `bmix_g_unit`

## Requirements
- R1: In the first half-step, a becomes a + b + x, with every addition taken modulo 2^64. A carry out of bit 63 is discarded.
- R2: In the first half-step, d becomes (d XOR new a) rotated right by 32. After that, c becomes c + new d.
- R3: In the first half-step, b becomes (b XOR new c) rotated right by 24. This rotation is a byte move: output byte k takes input byte (k+3) mod 8, where byte 0 is bits 7:0.
- R4: The second half-step works on the words produced by the first. It sets a = a + b + y and d = (d XOR a) rotated right by 16, which moves output byte k from input byte (k+2) mod 8. It then sets c = c + d.
- R5: The final b is (b XOR c) rotated right by 63, which is the same as a rotation left by 1.
- R6: valid_out equals valid_in delayed by exactly LATENCY clock cycles, where LATENCY is 0, 1 or 2 (default 2).
- R7: With LATENCY above 0, a synchronous active-low reset drives valid_out and all four result words to zero at the next clock edge.
- R8: The result words for a set of operands appear in the same cycle as the valid_out for that set. Operands presented on consecutive cycles produce results on consecutive cycles.
- R9: Operands with every bit set give the wrapped modulo-2^64 results, with no carry leaking into any other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operands on the inputs are meaningful this cycle |
| a_in | input | 64 | State word a |
| b_in | input | 64 | State word b |
| c_in | input | 64 | State word c |
| d_in | input | 64 | State word d |
| x_in | input | 64 | Message word used by the first half-step |
| y_in | input | 64 | Message word used by the second half-step |
| valid_out | output | 1 | Qualifier delayed by LATENCY cycles |
| a_out | output | 64 | Mixed word a |
| b_out | output | 64 | Mixed word b |
| c_out | output | 64 | Mixed word c |
| d_out | output | 64 | Mixed word d |

## Verification
Each half-step checks itself by undoing its rotations. The property rotl(d_new) XOR a_new == d_old must hold, and so must rotl(b_new) XOR c_new == b_old. Both are expected to hold for any operand values, so they place no constraint on the inputs. The latency property assumes only that the reset was held low for at least one clock edge, and it stays disabled until LATENCY edges have passed since reset. The stimulus respects both conditions: it holds reset for several cycles, then feeds random words, all-zero words and all-ones words. It feeds them back-to-back and also with gaps in valid_in.

// File: rtl/bmix_pkg.sv
// Package bmix_pkg
// Shared word and state types for the quarter-round mixer, plus the
// rotation helpers. Assumes a 64-bit word throughout.
package bmix_pkg;

    localparam int WORD_W  = 64;
    localparam int BYTES_W = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } quad_t;

    localparam int QUAD_W = $bits(quad_t);

    // Rotate right using a pair of shifts (any amount).
    function automatic word_t rotr_shift(input word_t v, input int amt);
        int s;
        s = amt % WORD_W;
        if (s == 0) return v;
        return (v >> s) | (v << (WORD_W - s));
    endfunction

    // Rotate left using a pair of shifts (any amount).
    function automatic word_t rotl_shift(input word_t v, input int amt);
        int s;
        s = amt % WORD_W;
        if (s == 0) return v;
        return (v << s) | (v >> (WORD_W - s));
    endfunction

    // Rotate right by whole bytes: output byte k takes input byte (k+nb) mod 8.
    function automatic word_t rotr_bytes(input word_t v, input int nb);
        word_t r;
        for (int k = 0; k < BYTES_W; k++) begin
            r[8*k +: 8] = v[8*((k + nb) % BYTES_W) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/bmix_rotr.sv
// Module bmix_rotr
// Constant right rotation of one word. When the amount is a whole number
// of bytes it is built as a byte move. Otherwise it is built from two
// shifts. Assumes 0 < AMT < 64.
module bmix_rotr
    import bmix_pkg::*;
#(
    parameter int AMT = 24
) (
    input  word_t x_i,
    output word_t y_o
);

    localparam bit BYTE_ALIGNED = (AMT % 8) == 0;
    localparam int BYTE_AMT     = AMT / 8;

    generate
        if (BYTE_ALIGNED) begin : g_bytes
            // Purpose: byte-lane permutation
            always_comb y_o = rotr_bytes(x_i, BYTE_AMT);
        end else begin : g_shift
            // Purpose: shift pair for amounts off the byte grid
            always_comb y_o = rotr_shift(x_i, AMT);
        end
    endgenerate

endmodule

// File: rtl/bmix_half.sv
// Module bmix_half
// One half-step of the mixer: a += b + m; d = rotr(d^a, ROT_D);
// c += d; b = rotr(b^c, ROT_B). Each operation uses the value that the
// operation before it has just produced. The logic is purely
// combinational. The clock and reset are used only by the assertions.
module bmix_half
    import bmix_pkg::*;
#(
    parameter int ROT_D = 32,
    parameter int ROT_B = 24
) (
    input  logic  clk,
    input  logic  rst_n,
    input  quad_t q_i,
    input  word_t m_i,
    output quad_t q_o
);

    word_t a_sum;
    word_t d_mix;
    word_t d_rot;
    word_t c_sum;
    word_t b_mix;
    word_t b_rot;

    // Purpose: add stage for a and XOR into d
    always_comb begin
        a_sum = q_i.a + q_i.b + m_i;
        d_mix = q_i.d ^ a_sum;
    end

    bmix_rotr #(.AMT(ROT_D)) u_rot_d (.x_i(d_mix), .y_o(d_rot));

    // Purpose: add stage for c and XOR into b
    always_comb begin
        c_sum = q_i.c + d_rot;
        b_mix = q_i.b ^ c_sum;
    end

    bmix_rotr #(.AMT(ROT_B)) u_rot_b (.x_i(b_mix), .y_o(b_rot));

    // Purpose: collect the updated words
    always_comb begin
        q_o.a = a_sum;
        q_o.b = b_rot;
        q_o.c = c_sum;
        q_o.d = d_rot;
    end

    // R2 / R4: undoing the d rotation and the XOR recovers the incoming d
    a_r2_d_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (rotl_shift(q_o.d, ROT_D) ^ q_o.a) == q_i.d);

    // R3 / R5: undoing the b rotation and the XOR recovers the incoming b
    a_r3_b_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (rotl_shift(q_o.b, ROT_B) ^ q_o.c) == q_i.b);

    // R1 / R4: new c minus new d gives back the incoming c
    a_r1_c_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o.c - q_o.d) == q_i.c);

endmodule

// File: rtl/bmix_stage.sv
// Module bmix_stage
// Pipeline register for a qualifier plus a W-bit payload. The payload is
// captured every cycle, whatever the qualifier. A synchronous active-low
// reset clears both.
module bmix_stage #(
    parameter int W = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_i,
    input  logic [W-1:0] d_i,
    output logic         v_o,
    output logic [W-1:0] d_o
);

    // Purpose: register the qualifier and the payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            d_o <= '0;
        end else begin
            v_o <= v_i;
            d_o <= d_i;
        end
    end

endmodule

// File: rtl/bmix_g_unit.sv
// Module bmix_g_unit
// BLAKE2b quarter-round mixer made of two half-steps: rotations 32/24
// with message x, then 16/63 with message y. LATENCY picks the number of
// register stages: 0 = fully combinational, 1 = output register,
// 2 = one register between the half-steps and one at the output.
// Assumes LATENCY is 0, 1 or 2.
module bmix_g_unit
    import bmix_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_in,
    input  logic [63:0] a_in,
    input  logic [63:0] b_in,
    input  logic [63:0] c_in,
    input  logic [63:0] d_in,
    input  logic [63:0] x_in,
    input  logic [63:0] y_in,
    output logic        valid_out,
    output logic [63:0] a_out,
    output logic [63:0] b_out,
    output logic [63:0] c_out,
    output logic [63:0] d_out
);

    localparam int MID_W = QUAD_W + WORD_W;

    quad_t q_in;
    quad_t q_mid;
    quad_t q_h1_in;
    word_t y_h1;
    logic  v_h1;
    quad_t q_h1_out;
    quad_t q_res;

    // Purpose: pack the input words
    always_comb begin
        q_in.a = a_in;
        q_in.b = b_in;
        q_in.c = c_in;
        q_in.d = d_in;
    end

    bmix_half #(.ROT_D(32), .ROT_B(24)) u_half0 (
        .clk  (clk),
        .rst_n(rst_n),
        .q_i  (q_in),
        .m_i  (x_in),
        .q_o  (q_mid)
    );

    generate
        if (LATENCY >= 2) begin : g_mid_reg
            logic [MID_W-1:0] mid_q;
            bmix_stage #(.W(MID_W)) u_mid (
                .clk  (clk),
                .rst_n(rst_n),
                .v_i  (valid_in),
                .d_i  ({q_mid, y_in}),
                .v_o  (v_h1),
                .d_o  (mid_q)
            );
            // Purpose: split the registered payload
            always_comb begin
                q_h1_in = mid_q[MID_W-1 -: QUAD_W];
                y_h1    = mid_q[WORD_W-1:0];
            end
        end else begin : g_mid_wire
            // Purpose: feed the second half-step directly
            always_comb begin
                q_h1_in = q_mid;
                y_h1    = y_in;
                v_h1    = valid_in;
            end
        end
    endgenerate

    bmix_half #(.ROT_D(16), .ROT_B(63)) u_half1 (
        .clk  (clk),
        .rst_n(rst_n),
        .q_i  (q_h1_in),
        .m_i  (y_h1),
        .q_o  (q_h1_out)
    );

    generate
        if (LATENCY >= 1) begin : g_out_reg
            logic [QUAD_W-1:0] out_q;
            bmix_stage #(.W(QUAD_W)) u_out (
                .clk  (clk),
                .rst_n(rst_n),
                .v_i  (v_h1),
                .d_i  (q_h1_out),
                .v_o  (valid_out),
                .d_o  (out_q)
            );
            // Purpose: view the output register as words
            always_comb q_res = out_q;

            // Cycles since reset, saturating; the latency check waits on it
            logic [1:0] since_rst;
            // Purpose: count clock edges taken out of reset
            always_ff @(posedge clk) begin
                if (!rst_n)                since_rst <= 2'd0;
                else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            end

            // R7: reset empties the output
            a_r7_reset_clear: assert property (@(posedge clk)
                !rst_n |=> (!valid_out && a_out == '0 && b_out == '0
                            && c_out == '0 && d_out == '0));

            if (LATENCY == 1) begin : g_chk1
                // R6: one-cycle qualifier delay
                a_r6_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
                    (since_rst >= 2'd1) |-> (valid_out == $past(valid_in)));
            end else begin : g_chk2
                // R6: two-cycle qualifier delay
                a_r6_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
                    (since_rst >= 2'd2) |-> (valid_out == $past(valid_in, 2)));
            end
        end else begin : g_out_wire
            // Purpose: combinational output path
            always_comb begin
                q_res     = q_h1_out;
                valid_out = v_h1;
            end
            // R6: zero latency passes the qualifier straight through
            a_r6_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
                valid_out == valid_in);
        end
    endgenerate

    // Purpose: unpack the result words
    always_comb begin
        a_out = q_res.a;
        b_out = q_res.b;
        c_out = q_res.c;
        d_out = q_res.d;
    end

endmodule

// File: tb/bmix_g_unit_bench.sv
// Directed bench for bmix_g_unit with the default two-cycle latency.
module bmix_g_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int MAXV       = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [63:0] a_in = '0, b_in = '0, c_in = '0, d_in = '0, x_in = '0, y_in = '0;
    logic        valid_out;
    logic [63:0] a_out, b_out, c_out, d_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [63:0] ea [MAXV];
    logic [63:0] eb [MAXV];
    logic [63:0] ec [MAXV];
    logic [63:0] ed [MAXV];
    bit          ev [MAXV];

    bmix_g_unit #(.LATENCY(LAT)) u_bmix_g_unit (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
        .x_in(x_in), .y_in(y_in), .valid_out(valid_out),
        .a_out(a_out), .b_out(b_out), .c_out(c_out), .d_out(d_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference rotations written from the requirements
    function automatic logic [63:0] ror(input logic [63:0] v, input int s);
        return (v >> s) | (v << (64 - s));
    endfunction

    function automatic logic [63:0] byte_move(input logic [63:0] v, input int nb);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*((k + nb) % 8) +: 8];
        return r;
    endfunction

    task automatic model(input logic [63:0] a, b, c, d, x, y,
                         output logic [63:0] ra, rb, rc, rd);
        a = a + b + x;                 // R1
        d = ror(d ^ a, 32);            // R2
        c = c + d;                     // R2
        b = byte_move(b ^ c, 3);       // R3
        a = a + b + y;                 // R4
        d = byte_move(d ^ a, 2);       // R4
        c = c + d;                     // R4
        b = {b[62:0] ^ c[62:0], b[63] ^ c[63]}; // R5: rotate left by 1
        ra = a; rb = b; rc = c; rd = d;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scenario: outputs held at zero during reset (R7)
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            valid_in = 1'b1;
            a_in = {$urandom, $urandom}; b_in = {$urandom, $urandom};
            c_in = {$urandom, $urandom}; d_in = {$urandom, $urandom};
            x_in = {$urandom, $urandom}; y_in = {$urandom, $urandom};
        end
        #1;
        chk("R7 valid_out in reset", {63'd0, valid_out}, 64'd0);
        chk("R7 a_out in reset", a_out, 64'd0);
        chk("R7 b_out in reset", b_out, 64'd0);
        chk("R7 c_out in reset", c_out, 64'd0);
        chk("R7 d_out in reset", d_out, 64'd0);
        @(negedge clk);
        valid_in = 1'b0;
        rst_n = 1'b1;
        repeat (LAT + 1) @(negedge clk);
        #1;
        chk("R6 R7 valid_out idle after reset", {63'd0, valid_out}, 64'd0);
    endtask

    // Scenario: a stream of operands; mode 0 random, 1 all ones, 2 zeros,
    // 3 mixed edges; gaps inserts idle cycles (R1-R6, R8, R9)
    task automatic t_stream(input int n, input int mode, input bit gaps);
        for (int i = 0; i < n + LAT; i++) begin
            @(negedge clk);
            if (i < n) begin
                logic [63:0] a, b, c, d, x, y;
                case (mode)
                    1: begin a = '1; b = '1; c = '1; d = '1; x = '1; y = '1; end
                    2: begin a = '0; b = '0; c = '0; d = '0; x = '0; y = '0; end
                    3: begin
                        a = '1; b = 64'd1; c = '1; d = {$urandom, $urandom};
                        x = 64'h8000_0000_0000_0000; y = '1;
                    end
                    default: begin
                        a = {$urandom, $urandom}; b = {$urandom, $urandom};
                        c = {$urandom, $urandom}; d = {$urandom, $urandom};
                        x = {$urandom, $urandom}; y = {$urandom, $urandom};
                    end
                endcase
                ev[i] = gaps ? ((i % 3) != 1) : 1'b1;
                valid_in = ev[i];
                a_in = a; b_in = b; c_in = c; d_in = d; x_in = x; y_in = y;
                model(a, b, c, d, x, y, ea[i], eb[i], ec[i], ed[i]);
            end else begin
                valid_in = 1'b0;
            end
            #1;
            if (i >= LAT) begin
                int j;
                j = i - LAT;
                chk("R6 R8 valid_out delay", {63'd0, valid_out}, {63'd0, ev[j]});
                chk(mode == 1 ? "R9 R1 R4 a_out" : "R1 R4 a_out", a_out, ea[j]);
                chk(mode == 1 ? "R9 R3 R5 b_out" : "R3 R5 b_out", b_out, eb[j]);
                chk(mode == 1 ? "R9 R2 R4 c_out" : "R2 R4 c_out", c_out, ec[j]);
                chk(mode == 1 ? "R9 R2 R4 d_out" : "R2 R4 d_out", d_out, ed[j]);
            end
        end
    endtask

    initial begin
        t_reset();
        t_stream(2, 2, 1'b0);
        t_stream(3, 1, 1'b0);
        t_stream(4, 3, 1'b0);
        t_stream(24, 0, 1'b0);
        t_stream(18, 0, 1'b1);
        t_reset();
        t_stream(6, 0, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule